// File: doc/BRIEF.md
# Timed Event Sequence Player

The player steps through a list of stored entries and emits 8-bit event codes at programmed tick offsets from a trigger. Each entry carries an event code, a small gating mask and a 32-bit tick stamp. A host loads the list through a plain write port (address plus entry fields). Once the player is armed, a rising edge on the selected trigger source starts a tick count. Whenever the count equals the stamp of the current entry, that entry's code is presented on the output with a one-cycle valid strobe. The entry's mask can suppress it, depending on live input levels and software mask bits.

A dedicated end code closes the list. What happens next is chosen by a run mode: stop, wait for another trigger, or start over at once. Pause and abort both halt a run and drop the player to the disarmed state. Pause keeps the position, so a later arm and trigger continues from where playback stopped. Abort rewinds to the first entry.

Top module: `evseq_player`

## Requirements
- R1: The store holds 2^ADDR_W entries (2048 by default) of {code[7:0], mask[3:0], stamp[31:0]}. A write pulse stores the presented entry at the given address whenever the player is not running.
- R2: trig_sel picks the trigger source: values 0..7 select mxc_out[0..7], 8 selects ac_sync, 9 selects sw_trig, 10 selects ext_trig, and any other value selects nothing. A trigger is a 0-to-1 transition of the selected source between two consecutive clock edges.
- R3: A trigger while armed starts the run with tick 0 evaluated in the trigger cycle. The tick advances by one per cycle. An entry whose stamp equals tick T has its code appear with evt_valid on the clock edge that ends tick T's cycle. Entries are emitted strictly in list order.
- R4: The first entry may carry stamp 0. Its code is then matched in the trigger cycle itself and is valid right after the edge that accepted the trigger.
- R5: An entry is suppressed (no strobe) when (entry mask AND (mask_in OR sw_mask)) is non-zero. Playback still moves past a suppressed entry.
- R6: Code 0x7F ends the list. It is emitted like any other entry (subject to R5), and the pointer and tick then return to entry 0 and tick 0.
- R7: run_mode 0 (single), and the unused value 3, disarm the player after the end code.
- R8: run_mode 1 (normal) re-arms the player after the end code, so the next trigger replays the list.
- R9: run_mode 2 (automatic) keeps running after the end code. Tick 0 of the next pass is evaluated in the very next cycle.
- R10: A pause pulse stops and disarms the player but keeps the entry pointer and tick. After arm and trigger, playback continues with the entry that was pending.
- R11: An abort pulse stops and disarms the player and clears the pointer and tick. Abort takes priority over every other command in the same cycle.
- R12: Host writes presented while a run is in progress are dropped.
- R13: A trigger is ignored while disarmed or while running, and an arm pulse is ignored while running.
- R14: A disarm pulse returns an armed, idle player to disarmed. During a run, the run completes and the player then ends disarmed whatever the run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host entry write strobe |
| wr_addr | input | ADDR_W | Entry address to write |
| wr_code | input | 8 | Event code of written entry |
| wr_mask | input | 4 | Mask of written entry |
| wr_stamp | input | 32 | Tick stamp of written entry |
| arm | input | 1 | Arm pulse |
| disarm | input | 1 | Disarm pulse |
| pause | input | 1 | Pause pulse |
| abort | input | 1 | Abort pulse |
| run_mode | input | 2 | End behaviour: 0 single, 1 normal, 2 automatic |
| trig_sel | input | SEL_W | Trigger source select |
| mxc_out | input | NUM_MXC | Counter outputs usable as triggers |
| ac_sync | input | 1 | Mains-synchronous trigger input |
| sw_trig | input | 1 | Software trigger input |
| ext_trig | input | 1 | External trigger input |
| mask_in | input | 4 | Live input levels for entry gating |
| sw_mask | input | 4 | Software bits for entry gating |
| evt_valid | output | 1 | Event strobe |
| evt_code | output | 8 | Event code, meaningful when evt_valid is high |

## Verification
The assertions assume that list stamps increase strictly and that the first entry is the only one allowed a stamp of 0. They also assume that a list ends with code 0x7F before the tick count could pass any stamp, and that trig_sel does not change during a run. The stimulus writes only lists that meet these conditions, holds trig_sel and run_mode steady across each run, and drives command pulses for one cycle each. It overlaps commands with running playback only in the ways that R10 to R14 define.

// File: rtl/evseq_pkg.sv
package evseq_pkg;

    localparam int CODE_W  = 8;
    localparam int MASK_W  = 4;
    localparam int STAMP_W = 32;
    localparam logic [CODE_W-1:0] END_CODE = 8'h7F;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } play_state_e;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_NORMAL = 2'd1,
        MODE_AUTO   = 2'd2,
        MODE_SPARE  = 2'd3
    } run_mode_e;

    typedef struct packed {
        logic [CODE_W-1:0]  code;
        logic [MASK_W-1:0]  mask;
        logic [STAMP_W-1:0] stamp;
    } entry_t;

    function automatic logic entry_blocked(input entry_t e,
                                           input logic [MASK_W-1:0] gate);
        return |(e.mask & gate);
    endfunction

    function automatic play_state_e state_after_end(input run_mode_e m,
                                                    input logic stop_req);
        if (stop_req) return ST_IDLE;
        case (m)
            MODE_NORMAL: return ST_ARMED;
            MODE_AUTO:   return ST_RUN;
            default:     return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/evseq_store.sv
module evseq_store
    import evseq_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  entry_t            wdata,
    input  logic [ADDR_W-1:0] raddr,
    output entry_t            rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/evseq_trig_sel.sv
module evseq_trig_sel #(
    parameter int NUM_MXC = 8,
    parameter int SEL_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_MXC-1:0] mxc,
    input  logic               ac,
    input  logic               sw,
    input  logic               ext,
    output logic               pulse
);
    localparam int NUM_SRC = NUM_MXC + 3;

    logic [NUM_SRC-1:0] src;
    logic               level;
    logic               level_q;

    for (genvar i = 0; i < NUM_MXC; i++) begin : g_mxc
        assign src[i] = mxc[i];
    end
    assign src[NUM_MXC]     = ac;
    assign src[NUM_MXC + 1] = sw;
    assign src[NUM_MXC + 2] = ext;

    always_comb begin
        level = 1'b0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (sel == SEL_W'(k)) level = src[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level;
    end

    assign pulse = level & ~level_q;

    AST_TRIG_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse); // R2

endmodule

// File: rtl/evseq_ctrl.sv
module evseq_ctrl
    import evseq_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              disarm,
    input  logic              pause,
    input  logic              abort,
    input  run_mode_e         run_mode,
    input  logic              trig,
    input  entry_t            entry,
    input  logic [MASK_W-1:0] gate,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic              running,
    output logic              evt_valid,
    output logic [CODE_W-1:0] evt_code
);
    localparam logic [ADDR_W-1:0] LAST_IDX = {ADDR_W{1'b1}};

    play_state_e        st_q, st_d;
    logic [ADDR_W-1:0]  ptr_q, ptr_d;
    logic [STAMP_W-1:0] tick_q, tick_d;
    logic               stop_q, stop_d;
    logic               valid_d;
    logic [CODE_W-1:0]  code_d;
    logic               go, hit, end_hit, stop_now;

    always_comb begin
        st_d     = st_q;
        ptr_d    = ptr_q;
        tick_d   = tick_q;
        stop_d   = stop_q;
        valid_d  = 1'b0;
        code_d   = evt_code;
        go       = 1'b0;
        hit      = 1'b0;
        end_hit  = 1'b0;
        stop_now = stop_q;
        if (abort) begin
            st_d   = ST_IDLE;
            ptr_d  = '0;
            tick_d = '0;
            stop_d = 1'b0;
        end else if (pause) begin
            st_d = ST_IDLE;
        end else begin
            if (disarm) begin
                if (st_q == ST_ARMED)    st_d = ST_IDLE;
                else if (st_q == ST_RUN) stop_now = 1'b1;
            end else if (arm && st_q == ST_IDLE) begin
                st_d     = ST_ARMED;
                stop_now = 1'b0;
            end
            go     = (st_q == ST_ARMED && trig && !disarm) || st_q == ST_RUN;
            stop_d = stop_now;
            if (go) begin
                st_d = ST_RUN;
                hit  = (tick_q == entry.stamp);
                if (hit) begin
                    valid_d = !entry_blocked(entry, gate);
                    code_d  = entry.code;
                    end_hit = (entry.code == END_CODE) || (ptr_q == LAST_IDX);
                    if (end_hit) begin
                        ptr_d  = '0;
                        tick_d = '0;
                        stop_d = 1'b0;
                        st_d   = state_after_end(run_mode, stop_now);
                    end else begin
                        ptr_d  = ptr_q + 1'b1;
                        tick_d = tick_q + 1'b1;
                    end
                end else begin
                    tick_d = tick_q + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            ptr_q     <= '0;
            tick_q    <= '0;
            stop_q    <= 1'b0;
            evt_valid <= 1'b0;
            evt_code  <= '0;
        end else begin
            st_q      <= st_d;
            ptr_q     <= ptr_d;
            tick_q    <= tick_d;
            stop_q    <= stop_d;
            evt_valid <= valid_d;
            evt_code  <= code_d;
        end
    end

    assign rd_ptr  = ptr_q;
    assign running = (st_q == ST_RUN);

    AST_ABORT_REWINDS: assert property (@(posedge clk) disable iff (rst)
        abort |=> (ptr_q == '0 && tick_q == '0 && st_q == ST_IDLE)); // R11
    AST_PAUSE_KEEPS_PLACE: assert property (@(posedge clk) disable iff (rst)
        (pause && !abort) |=> (st_q == ST_IDLE && $stable(ptr_q) && $stable(tick_q))); // R10
    AST_IDLE_IS_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |=> !evt_valid); // R13
    AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (rst)
        (end_hit && !abort && !pause && (run_mode == MODE_SINGLE || run_mode == MODE_SPARE))
        |=> st_q == ST_IDLE); // R7
    AST_AUTO_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        (end_hit && !abort && !pause && !stop_now && run_mode == MODE_AUTO)
        |=> (st_q == ST_RUN && tick_q == '0)); // R9

endmodule

// File: rtl/evseq_player.sv
module evseq_player
    import evseq_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int NUM_MXC = 8,
    parameter int SEL_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [7:0]         wr_code,
    input  logic [3:0]         wr_mask,
    input  logic [31:0]        wr_stamp,
    input  logic               arm,
    input  logic               disarm,
    input  logic               pause,
    input  logic               abort,
    input  logic [1:0]         run_mode,
    input  logic [SEL_W-1:0]   trig_sel,
    input  logic [NUM_MXC-1:0] mxc_out,
    input  logic               ac_sync,
    input  logic               sw_trig,
    input  logic               ext_trig,
    input  logic [3:0]         mask_in,
    input  logic [3:0]         sw_mask,
    output logic               evt_valid,
    output logic [7:0]         evt_code
);
    entry_t            wr_entry, rd_entry;
    logic [ADDR_W-1:0] rd_ptr;
    logic              running;
    logic              store_we;
    logic              trig_pulse;

    assign wr_entry = '{code: wr_code, mask: wr_mask, stamp: wr_stamp};
    assign store_we = wr_en & ~running;

    evseq_store #(.ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (store_we),
        .waddr (wr_addr),
        .wdata (wr_entry),
        .raddr (rd_ptr),
        .rdata (rd_entry)
    );

    evseq_trig_sel #(.NUM_MXC(NUM_MXC), .SEL_W(SEL_W)) u_trig (
        .clk   (clk),
        .rst   (rst),
        .sel   (trig_sel),
        .mxc   (mxc_out),
        .ac    (ac_sync),
        .sw    (sw_trig),
        .ext   (ext_trig),
        .pulse (trig_pulse)
    );

    evseq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .disarm    (disarm),
        .pause     (pause),
        .abort     (abort),
        .run_mode  (run_mode_e'(run_mode)),
        .trig      (trig_pulse),
        .entry     (rd_entry),
        .gate      (mask_in | sw_mask),
        .rd_ptr    (rd_ptr),
        .running   (running),
        .evt_valid (evt_valid),
        .evt_code  (evt_code)
    );

    AST_NO_WRITE_WHILE_RUNNING: assert property (@(posedge clk) disable iff (rst)
        running |-> !store_we); // R12

endmodule

// File: tb/evseq_player_test.sv
module evseq_player_test;
    localparam int ADDR_W = 11;
    localparam int DEPTH  = 1 << ADDR_W;

    logic clk = 0;
    logic rst = 1;
    logic wr_en = 0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]  wr_code = '0;
    logic [3:0]  wr_mask = '0;
    logic [31:0] wr_stamp = '0;
    logic arm = 0, disarm = 0, pause = 0, abort = 0;
    logic [1:0] run_mode = 0;
    logic [3:0] trig_sel = 4'd9;
    logic [7:0] mxc_out = '0;
    logic ac_sync = 0, sw_trig = 0, ext_trig = 0;
    logic [3:0] mask_in = '0, sw_mask = '0;
    logic evt_valid;
    logic [7:0] evt_code;

    always #2 clk = ~clk;

    evseq_player #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code),
        .wr_mask(wr_mask), .wr_stamp(wr_stamp), .arm(arm), .disarm(disarm),
        .pause(pause), .abort(abort), .run_mode(run_mode), .trig_sel(trig_sel),
        .mxc_out(mxc_out), .ac_sync(ac_sync), .sw_trig(sw_trig), .ext_trig(ext_trig),
        .mask_in(mask_in), .sw_mask(sw_mask), .evt_valid(evt_valid), .evt_code(evt_code)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int ncyc = 0;
    bit done = 0;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_code [DEPTH];
    int m_mask [DEPTH];
    longint m_stamp [DEPTH];
    int m_st = 0;            // 0 disarmed, 1 armed, 2 running
    int m_ptr = 0;
    longint m_tick = 0;
    bit m_stop = 0;
    bit m_prev = 0;
    bit exp_valid = 0;
    int exp_code = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_ptr = 0; m_tick = 0; m_stop = 0; m_prev = 0; exp_valid = 0;
        end else begin
            int st0;
            bit s, trg, run_it;
            st0 = m_st;
            if (trig_sel < 8)        s = mxc_out[trig_sel[2:0]];
            else if (trig_sel == 8)  s = ac_sync;
            else if (trig_sel == 9)  s = sw_trig;
            else if (trig_sel == 10) s = ext_trig;
            else                     s = 0;
            trg = s && !m_prev;
            m_prev = s;
            exp_valid = 0;
            if (abort) begin
                m_st = 0; m_ptr = 0; m_tick = 0; m_stop = 0;
            end else if (pause) begin
                m_st = 0;
            end else begin
                run_it = (st0 == 2) || (st0 == 1 && trg && !disarm);
                if (disarm) begin
                    if (st0 == 1) m_st = 0;
                    else if (st0 == 2) m_stop = 1;
                end else if (arm && st0 == 0) begin
                    m_st = 1; m_stop = 0;
                end
                if (run_it) begin
                    m_st = 2;
                    if (m_tick == m_stamp[m_ptr]) begin
                        if ((m_mask[m_ptr] & (mask_in | sw_mask)) == 0) begin
                            exp_valid = 1;
                            exp_code = m_code[m_ptr];
                        end
                        if (m_code[m_ptr] == 8'h7F || m_ptr == DEPTH - 1) begin
                            if (m_stop || run_mode == 0 || run_mode == 3) m_st = 0;
                            else if (run_mode == 1) m_st = 1;
                            else m_st = 2;
                            m_stop = 0; m_ptr = 0; m_tick = 0;
                        end else begin
                            m_ptr++; m_tick++;
                        end
                    end else begin
                        m_tick++;
                    end
                end
            end
            if (wr_en && st0 != 2) begin
                m_code[wr_addr]  = wr_code;
                m_mask[wr_addr]  = wr_mask;
                m_stamp[wr_addr] = wr_stamp;
            end
        end
    end

    // ---------------- monitor and per-cycle comparison ----------------
    int got_code [$];
    int got_at [$];

    always @(negedge clk) begin
        ncyc++;
        if (!rst && !done) begin
            checks++;
            if (evt_valid !== exp_valid || (exp_valid && evt_code !== exp_code[7:0])) begin
                fails++;
                $display("FAIL R3 per-cycle model: actual v=%0b code=%0h expected v=%0b code=%0h",
                         evt_valid, evt_code, exp_valid, exp_code);
            end
            if (evt_valid) begin
                got_code.push_back(evt_code);
                got_at.push_back(ncyc);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL R3 watchdog expired actual=%0d expected<=60000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input int a, input int c, input int m, input int st);
        wr_en = 1; wr_addr = a[ADDR_W-1:0]; wr_code = c[7:0]; wr_mask = m[3:0]; wr_stamp = st;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic do_arm();    arm = 1;    @(negedge clk); arm = 0;    endtask
    task automatic do_disarm(); disarm = 1; @(negedge clk); disarm = 0; endtask
    task automatic do_pause();  pause = 1;  @(negedge clk); pause = 0;  endtask
    task automatic do_abort();  abort = 1;  @(negedge clk); abort = 0;  endtask
    task automatic sw_pulse();  sw_trig = 1; @(negedge clk); sw_trig = 0; endtask

    task automatic clear_log();
        got_code.delete();
        got_at.delete();
    endtask

    initial begin
        idle(3);
        rst = 0;
        check("R3 reset: no event", evt_valid, 0);

        // List A: code, mask, stamp
        wr(0, 8'h11, 0, 0);
        wr(1, 8'h22, 0, 3);
        wr(2, 8'h33, 1, 4);
        wr(3, 8'h7F, 0, 6);
        mask_in = 4'b0001;
        run_mode = 0; trig_sel = 9;

        clear_log();
        do_arm();
        sw_trig = 1; @(negedge clk); sw_trig = 0;
        check("R4 stamp-zero entry valid after trigger edge", evt_valid, 1);
        check("R4 stamp-zero entry code", evt_code, 8'h11);
        idle(10);
        check("R5 masked entry dropped, count", got_code.size(), 3);
        if (got_code.size() == 3) begin
            check("R3 list order second code", got_code[1], 8'h22);
            check("R3 stamp spacing 0->3", got_at[1] - got_at[0], 3);
            check("R6 end code emitted", got_code[2], 8'h7F);
            check("R5 pointer advanced past masked entry, end at tick 6", got_at[2] - got_at[0], 6);
        end

        clear_log();
        sw_pulse(); idle(10);
        check("R7 single mode disarmed after end", got_code.size(), 0);

        // normal mode
        run_mode = 1;
        clear_log();
        do_arm(); sw_pulse(); idle(10); sw_pulse(); idle(10);
        check("R8 normal mode re-arms, two runs", got_code.size(), 6);
        clear_log();
        sw_pulse(); idle(2); sw_pulse(); idle(10);
        check("R13 trigger during run ignored", got_code.size(), 3);
        clear_log();
        do_disarm(); sw_pulse(); idle(10);
        check("R14 disarm from armed", got_code.size(), 0);
        clear_log();
        do_arm(); sw_pulse(); idle(2); do_disarm(); idle(10);
        check("R14 run finishes after disarm", got_code.size(), 3);
        clear_log();
        sw_pulse(); idle(10);
        check("R14 disarmed after run despite normal mode", got_code.size(), 0);

        // automatic mode
        run_mode = 2; mask_in = 0;
        clear_log();
        do_arm(); sw_pulse(); idle(20);
        check("R9 automatic restart gives repeated passes", got_code.size() >= 8, 1);
        if (got_code.size() >= 5)
            check("R9 next pass begins the cycle after end", got_at[4] - got_at[3], 1);
        do_abort();
        clear_log();
        idle(10);
        check("R11 abort stops automatic run", got_code.size(), 0);

        // List B, triggered from counter output 3
        wr(0, 8'h41, 0, 0);
        wr(1, 8'h42, 0, 10);
        wr(2, 8'h43, 0, 20);
        wr(3, 8'h7F, 0, 30);
        run_mode = 0; trig_sel = 3;
        clear_log();
        do_arm(); mxc_out[3] = 1; @(negedge clk); mxc_out[3] = 0;
        idle(12); do_pause(); idle(30);
        check("R10 pause halts output", got_code.size(), 2);
        do_arm(); mxc_out[3] = 1; @(negedge clk); mxc_out[3] = 0;
        idle(25);
        check("R10 resume count", got_code.size(), 4);
        if (got_code.size() == 4) check("R10 resume continues at pending entry", got_code[2], 8'h43);

        clear_log();
        do_arm(); mxc_out[3] = 1; @(negedge clk); mxc_out[3] = 0;
        idle(5);
        wr(2, 8'h55, 0, 20);
        idle(6); do_abort(); idle(4);
        do_arm(); mxc_out[3] = 1; @(negedge clk); mxc_out[3] = 0;
        idle(35);
        check("R11 abort rewinds, total count", got_code.size(), 6);
        if (got_code.size() == 6) begin
            check("R11 rerun starts at first entry", got_code[2], 8'h41);
            check("R12 write during run dropped", got_code[4], 8'h43);
        end

        clear_log();
        wr(2, 8'h56, 0, 20);
        wr(1, 8'h42, 4'b0010, 10);
        sw_mask = 4'b0010;
        trig_sel = 8;
        do_arm(); ac_sync = 1; @(negedge clk); ac_sync = 0; idle(35);
        check("R5 software mask drops entry; R2 ac source", got_code.size(), 3);
        if (got_code.size() == 3) check("R1 write while idle stored", got_code[1], 8'h56);
        sw_mask = 0;

        clear_log();
        trig_sel = 10;
        do_arm(); mxc_out[3] = 1; @(negedge clk); mxc_out[3] = 0; idle(5);
        check("R2 unselected source ignored", got_code.size(), 0);
        ext_trig = 1; @(negedge clk); ext_trig = 0; idle(35);
        check("R2 ext source triggers", got_code.size(), 4);

        clear_log();
        do_arm(); trig_sel = 12;
        ext_trig = 1; sw_trig = 1; ac_sync = 1; mxc_out = 8'hFF; @(negedge clk);
        ext_trig = 0; sw_trig = 0; ac_sync = 0; mxc_out = 0; idle(5);
        check("R2 select value 12 picks no source", got_code.size(), 0);
        do_abort();

        clear_log();
        trig_sel = 9; run_mode = 3;
        do_arm(); sw_pulse(); idle(35); sw_pulse(); idle(35);
        check("R7 mode 3 behaves as single", got_code.size(), 4);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule